// File: doc/BRIEF.md
# Conditional Wait Unit with Holdoff and Timeout

This unit lets a controller hand off a "wait until something becomes true" step. A one-cycle start pulse makes it capture three settings: a holdoff length, a limit on the number of polls, and whether that limit applies. The unit first lets the holdoff clocks pass. It then samples a multi-bit condition input once per clock until the sampled value is non-zero or the poll limit runs out.

When the wait ends, the unit gives a one-cycle completion pulse, a flag that says whether the limit was the reason, and a result word. The result is the condition value captured at the deciding clock edge, or zero when the wait gave up. The controller reads the flag and the result in the same cycle as the pulse. Both stay stable until the next wait finishes.

Top module: `condWait`

## Requirements
- R1: After reset, `busy`, `done` and `timedOut` are 0 and `result` is all zeros.
- R2: A `start` sampled high while idle begins a wait, and `busy` is 1 from the next cycle. `busy` is 0 again in the cycle where `done` is 1.
- R3: With holdoff `startDelay` = D, the first condition sample is taken at the (D+1)-th rising edge after the edge that accepted `start`. Condition values present at earlier edges have no effect.
- R4: The wait ends at the first sampling edge where `cond` is non-zero. In the following cycle `done` is 1, `timedOut` is 0 and `result` equals the `cond` value sampled at that edge.
- R5: With `timeoutEn` = 1 and limit `timeoutCnt` = T, the wait ends after max(T,1) consecutive zero samples. In the following cycle `done` is 1, `timedOut` is 1 and `result` is zero. A limit of 0 behaves like a limit of 1.
- R6: With `timeoutEn` = 0, the unit keeps polling for as many clocks as needed and never reports `timedOut` = 1.
- R7: A `start` pulse while `busy` is 1 is ignored. The running wait keeps the settings it captured at its own start.
- R8: `done` is high for exactly one cycle per wait. `result` and `timedOut` keep their values until the next completion.
- R9: With D = 0 and `timeoutEn` = 0, the condition is sampled at the first edge after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a wait (accepted only when idle) |
| startDelay | input | CNT_W | Holdoff clocks before polling starts |
| timeoutCnt | input | CNT_W | Maximum number of polls |
| timeoutEn | input | 1 | Apply the poll limit |
| cond | input | DATA_W | Condition value; any non-zero value counts as true |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | The last wait ended on the poll limit |
| result | output | DATA_W | Condition value captured at completion, or zero on timeout |

## Verification
Some properties are checked by assertions on every cycle:
- `done` never lasts two cycles.
- `busy` falls only together with `done`.
- A timeout always returns zero, and a successful poll always returns a non-zero value.
- `result` does not move between completions.
- A timeout is reported only when the accepted start had the limit enabled.

The exact cycle on which a wait ends can only be shown by the bench scenarios. That covers the holdoff length, decoy non-zero values during the holdoff, the limit-of-zero case, an unlimited wait, and a second start pulse arriving mid-wait.

// File: rtl/condWaitPkg.sv
package condWaitPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_POLL = 2'd2
  } waitState_t;

  typedef struct packed {
    logic load;       // capture settings
    logic holdDec;    // count down holdoff
    logic pollInc;    // one more failed poll
    logic finishHit;  // condition seen non-zero
    logic finishTmo;  // poll limit reached
  } waitStrobes_t;
endpackage

// File: rtl/condWaitCtrl.sv
module condWaitCtrl
  import condWaitPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         startZero,
  input  logic         holdLast,
  input  logic         condHit,
  input  logic         pollLast,
  output waitStrobes_t strobes,
  output logic         busy
);
  waitState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateNext    = startZero ? ST_POLL : ST_HOLD;
        end
      end
      ST_HOLD: begin
        strobes.holdDec = 1'b1;
        if (holdLast) stateNext = ST_POLL;
      end
      ST_POLL: begin
        if (condHit) begin
          strobes.finishHit = 1'b1;
          stateNext         = ST_IDLE;
        end else if (pollLast) begin
          strobes.finishTmo = 1'b1;
          stateNext         = ST_IDLE;
        end else begin
          strobes.pollInc = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/condWaitDp.sv
module condWaitDp
  import condWaitPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  waitStrobes_t      strobes,
  input  logic [CNT_W-1:0]  startDelay,
  input  logic [CNT_W-1:0]  timeoutCnt,
  input  logic              timeoutEn,
  input  logic [DATA_W-1:0] cond,
  output logic              startZero,
  output logic              holdLast,
  output logic              condHit,
  output logic              pollLast,
  output logic              done,
  output logic              timedOut,
  output logic [DATA_W-1:0] result
);
  localparam int CMP_W = CNT_W + 1;

  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W-1:0] pollCnt;
  logic [CNT_W-1:0] limitReg;
  logic             limitEn;
  logic [CMP_W-1:0] pollNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      pollCnt  <= '0;
      limitReg <= '0;
      limitEn  <= 1'b0;
    end else if (strobes.load) begin
      holdCnt  <= startDelay;
      pollCnt  <= '0;
      limitReg <= timeoutCnt;
      limitEn  <= timeoutEn;
    end else begin
      if (strobes.holdDec) holdCnt <= holdCnt - 1'b1;
      if (strobes.pollInc) pollCnt <= pollCnt + 1'b1;
    end
  end

  assign pollNext  = {1'b0, pollCnt} + CMP_W'(1);
  assign startZero = (startDelay == '0);
  assign holdLast  = (holdCnt == CNT_W'(1));
  assign condHit   = (cond != '0);
  assign pollLast  = limitEn && (pollNext >= {1'b0, limitReg});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      timedOut <= 1'b0;
      result   <= '0;
    end else begin
      done <= strobes.finishHit | strobes.finishTmo;
      if (strobes.finishHit) begin
        result   <= cond;
        timedOut <= 1'b0;
      end else if (strobes.finishTmo) begin
        result   <= '0;
        timedOut <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/condWait.sv
module condWait
  import condWaitPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  startDelay,
  input  logic [CNT_W-1:0]  timeoutCnt,
  input  logic              timeoutEn,
  input  logic [DATA_W-1:0] cond,
  output logic              busy,
  output logic              done,
  output logic              timedOut,
  output logic [DATA_W-1:0] result
);
  waitStrobes_t strobes;
  logic startZero, holdLast, condHit, pollLast;

  condWaitCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .startZero(startZero), .holdLast(holdLast),
    .condHit(condHit), .pollLast(pollLast),
    .strobes(strobes), .busy(busy)
  );

  condWaitDp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .startDelay(startDelay), .timeoutCnt(timeoutCnt), .timeoutEn(timeoutEn),
    .cond(cond), .startZero(startZero), .holdLast(holdLast),
    .condHit(condHit), .pollLast(pollLast),
    .done(done), .timedOut(timedOut), .result(result)
  );
endmodule

// File: rtl/condWaitChecker.sv
module condWaitChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              timeoutEn,
  input logic              busy,
  input logic              done,
  input logic              timedOut,
  input logic [DATA_W-1:0] result
);
  logic enSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enSeen <= 1'b0;
    else if (!busy && start) enSeen <= timeoutEn;
  end

  AST_START_BUSY:   assert property (@(posedge clk) disable iff (!rstN) (!busy && start) |=> busy);           // R2
  AST_BUSY_DROP:    assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);                // R2
  AST_HIT_NONZERO:  assert property (@(posedge clk) disable iff (!rstN) (done && !timedOut) |-> (result != '0)); // R4
  AST_TMO_ZERO:     assert property (@(posedge clk) disable iff (!rstN) (done && timedOut) |-> (result == '0));  // R5
  AST_TMO_ENABLED:  assert property (@(posedge clk) disable iff (!rstN) (done && timedOut) |-> enSeen);       // R6
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rstN) done |=> !done);                      // R8
  AST_RESULT_HOLD:  assert property (@(posedge clk) disable iff (!rstN) !done |-> ($stable(result) && $stable(timedOut))); // R8
endmodule

bind condWait condWaitChecker #(.DATA_W(DATA_W)) u_condWaitChecker (
  .clk(clk), .rstN(rstN), .start(start), .timeoutEn(timeoutEn),
  .busy(busy), .done(done), .timedOut(timedOut), .result(result)
);

// File: tb/condWait_bench.sv
module condWait_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int NVEC   = 9;

  typedef struct packed {
    logic [7:0] dly;
    logic [7:0] tmo;
    logic       en;
    logic [7:0] hitIdx;   // poll index where cond becomes non-zero
    logic [7:0] val;
    logic       restart;  // extra start pulse mid-wait
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'd0, 8'd0, 1'b0, 8'd0,  8'h5A, 1'b0},
    '{8'd2, 8'd2, 1'b1, 8'd0,  8'h33, 1'b0},
    '{8'd2, 8'd2, 1'b1, 8'd5,  8'h44, 1'b0},
    '{8'd0, 8'd0, 1'b1, 8'd3,  8'h12, 1'b0},
    '{8'd3, 8'd4, 1'b1, 8'd3,  8'h81, 1'b0},
    '{8'd1, 8'd0, 1'b0, 8'd20, 8'h01, 1'b0},
    '{8'd5, 8'd3, 1'b1, 8'd1,  8'hFF, 1'b1},
    '{8'd4, 8'd1, 1'b1, 8'd0,  8'h7E, 1'b0},
    '{8'd0, 8'd6, 1'b1, 8'd6,  8'h09, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0]  startDelay = '0;
  logic [CNT_W-1:0]  timeoutCnt = '0;
  logic              timeoutEn = 1'b0;
  logic [DATA_W-1:0] cond = '0;
  logic busy, done, timedOut;
  logic [DATA_W-1:0] result;

  int nChecks = 0;
  int nFails  = 0;

  condWait #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_condWait (
    .clk(clk), .rstN(rstN), .start(start), .startDelay(startDelay),
    .timeoutCnt(timeoutCnt), .timeoutEn(timeoutEn), .cond(cond),
    .busy(busy), .done(done), .timedOut(timedOut), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input string tag);
    int lim, endEdge, seen;
    logic expTmo;
    logic [DATA_W-1:0] expRes, keepRes;
    lim = (v.tmo == 0) ? 1 : int'(v.tmo);
    if (!v.en || int'(v.hitIdx) < lim) begin
      endEdge = int'(v.dly) + 1 + int'(v.hitIdx); expTmo = 1'b0; expRes = v.val;
    end else begin
      endEdge = int'(v.dly) + lim; expTmo = 1'b1; expRes = '0;
    end
    @(negedge clk);
    start = 1'b1; startDelay = v.dly; timeoutCnt = v.tmo; timeoutEn = v.en; cond = '0;
    @(posedge clk);
    seen = 0;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (v.restart && k == 1) begin
        start = 1'b1; startDelay = '0; timeoutCnt = 8'd1; timeoutEn = 1'b1;   // R7 decoy
      end
      if (k <= int'(v.dly)) cond = 8'hEE;                                  // R3 decoy
      else cond = (k - int'(v.dly) - 1 == int'(v.hitIdx)) ? v.val : '0;
      @(posedge clk); #1;
      if (k == 1 && !done) check({tag, " R2 busy"}, busy, 1);
      if (done) begin seen = k; break; end
    end
    check({tag, " R3/R5 end edge"}, seen, endEdge);
    check({tag, " R4/R5 result"}, result, expRes);
    check({tag, " R5/R6 timedOut"}, timedOut, expTmo);
    check({tag, " R2 idle at done"}, busy, 0);
    keepRes = result;
    @(negedge clk); start = 1'b0; cond = 8'hC3;
    @(posedge clk); #1;
    check({tag, " R8 pulse"}, done, 0);
    check({tag, " R8 hold"}, {timedOut, result}, {expTmo, keepRes});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 timedOut", timedOut, 0);
    check("R1 result", result, 0);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) runVec(VECS[i], $sformatf("vec%0d", i));
    // R9: zero holdoff, no limit, back-to-back with cond already non-zero
    runVec('{8'd0, 8'd0, 1'b0, 8'd0, 8'hA5, 1'b0}, "R9 immediate");
    // R6: long unlimited wait
    runVec('{8'd0, 8'd0, 1'b0, 8'd120, 8'h3C, 1'b0}, "R6 long");
    // R5: limit reached exactly on last poll with hit one poll too late
    runVec('{8'd1, 8'd3, 1'b1, 8'd3, 8'h55, 1'b0}, "R5 edge");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule